// File: doc/BRIEF.md
# Burst Address Sequencer with Wrap Control

This block generates word addresses on the device side of a memory that shares one 16-bit bus between addresses and data. A 23-bit word address is split across the shared bus, which carries bits 15..0, and seven address-only lines, which carry bits 22..16. An active-low address-valid strobe qualifies the address. In synchronous burst operation, the first clock edge that sees chip enable and the strobe both low captures the start address. After a programmable initial latency the block raises a ready flag. It then steps the address once per clock in one of seven burst patterns: continuous linear, wrap within 8/16/32 words, or a linear run of 8/16/32 words that stops.

When burst operation is disabled the block serves single-word asynchronous reads. The address flows through as long as the strobe and chip enable are low, and no counting takes place. Reset places the block in the idle state with a zero address. The memory array reads the `word_addr` output. The host-side ready line is driven from `data_rdy`.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `word_addr` is 0 and the sequencer is idle. `data_rdy` is 1 while `burst_en` is 0 and 0 while `burst_en` is 1 with no burst started.
- R2: With `burst_en`=1, a rising clock edge with `ce_n`=0 and `addr_vld_n`=0 loads `{addr_hi, ad_bus}` into `word_addr` and drops `data_rdy` to 0. Bus values seen after that edge while the strobe is high are ignored.
- R3: `data_rdy` rises exactly max(`init_lat`,1) clock edges after the capturing edge. `word_addr` holds the start address during that wait.
- R4: Mode code 3'b000 (continuous) adds 1 to the full 23-bit address on every edge while ready, and rolls over from 0x7FFFFF to 0.
- R5: Mode codes 3'b001/3'b010/3'b011 (wrap 8/16/32) step only the low 3/4/5 address bits modulo the burst length, keep all higher bits fixed, and never drop ready.
- R6: Mode codes 3'b100/3'b101/3'b110 (linear 8/16/32) step the full address, crossing length-aligned boundaries.
- R7: In the linear fixed-length modes, `data_rdy` stays high for exactly N addresses and then falls. `word_addr` holds the last address until the next capture, and a new capture starts a fresh burst.
- R8: The unused mode code 3'b111 behaves as continuous.
- R9: With `burst_en`=0, `word_addr` shows `{addr_hi, ad_bus}` combinationally while `ce_n` and `addr_vld_n` are low. The last value captured on an edge is held once the strobe rises, clock edges never advance it, and `data_rdy` stays 1.
- R10: With `burst_en`=1, an edge with `ce_n`=1 ends any burst. `data_rdy` is 0 from then on and the address holds until a new capture.
- R11: A capture edge during an active burst restarts it with the new address, mode and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| addr_vld_n | input | 1 | Active-low address-valid strobe |
| ad_bus | input | 16 | Shared bus, address bits 15..0 |
| addr_hi | input | 7 | Address-only bits 22..16 |
| burst_en | input | 1 | 1 = synchronous burst, 0 = asynchronous single access |
| burst_mode | input | 3 | Burst pattern code, sampled at capture |
| init_lat | input | 4 | Initial latency in clocks, sampled at capture (0 acts as 1) |
| word_addr | output | 23 | Current word address |
| data_rdy | output | 1 | High when the current word is valid |

## Verification
A table of all eight mode codes drives start addresses chosen to sit near a wrap edge, near a 2^23 rollover or inside a length-aligned window. Each case exposes a different step rule: a wrong wrap mask changes the upper bits, and a wrong linear step fails to cross the boundary. Latencies of 0 through 4 separate an off-by-one in the ready delay from a correct one. Directed cases target the asynchronous pass-through and its hold, a chip-enable drop mid-burst, a capture during an active burst, and a fresh capture after a finished linear burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_WAIT  = 2'd1,
      SEQ_BURST = 2'd2,
      SEQ_DONE  = 2'd3
   } seq_state_e;

   localparam logic [2:0] MODE_LINEAR_CONT = 3'b000;
   localparam logic [2:0] MODE_WRAP_S      = 3'b001;
   localparam logic [2:0] MODE_WRAP_M      = 3'b010;
   localparam logic [2:0] MODE_WRAP_L      = 3'b011;
   localparam logic [2:0] MODE_FIXED_S     = 3'b100;
   localparam logic [2:0] MODE_FIXED_M     = 3'b101;
   localparam logic [2:0] MODE_FIXED_L     = 3'b110;
   localparam logic [2:0] MODE_SPARE       = 3'b111;

endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec #(
   parameter int MIN_LEN_LOG2 = 3,
   parameter int LEN_W        = 3
) (
   input  logic [2:0]       mode_code,
   output logic             wrap_o,
   output logic             fixed_o,
   output logic [LEN_W-1:0] len_log2_o
);
   import burst_seq_pkg::*;

   localparam logic [LEN_W-1:0] LG_S = LEN_W'(MIN_LEN_LOG2);
   localparam logic [LEN_W-1:0] LG_M = LEN_W'(MIN_LEN_LOG2 + 1);
   localparam logic [LEN_W-1:0] LG_L = LEN_W'(MIN_LEN_LOG2 + 2);

   generate
      if (MIN_LEN_LOG2 + 2 >= (1 << LEN_W)) begin : g_len_w_chk
         $error("burst_mode_dec: LEN_W too narrow for largest burst length");
      end
   endgenerate

   always_comb begin
      wrap_o     = 1'b0;
      fixed_o    = 1'b0;
      len_log2_o = LG_S;
      case (mode_code)
         MODE_WRAP_S:  begin wrap_o  = 1'b1; len_log2_o = LG_S; end
         MODE_WRAP_M:  begin wrap_o  = 1'b1; len_log2_o = LG_M; end
         MODE_WRAP_L:  begin wrap_o  = 1'b1; len_log2_o = LG_L; end
         MODE_FIXED_S: begin fixed_o = 1'b1; len_log2_o = LG_S; end
         MODE_FIXED_M: begin fixed_o = 1'b1; len_log2_o = LG_M; end
         MODE_FIXED_L: begin fixed_o = 1'b1; len_log2_o = LG_L; end
         default:      begin wrap_o  = 1'b0; fixed_o = 1'b0; end
      endcase
   end

   always_comb begin
      a_r5_wrap_fixed_excl: assert (!(wrap_o && fixed_o));
   end

endmodule

// File: rtl/burst_lat_ctr.sv
module burst_lat_ctr #(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LAT_W-1:0] lat_i,
   input  logic             run_i,
   output logic             expired_o
);
   localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

   logic [LAT_W-1:0] cnt_q;

   generate
      if (LAT_W < 1) begin : g_lat_w_chk
         $error("burst_lat_ctr: LAT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= lat_i;
      end else if (run_i && (cnt_q > ONE)) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign expired_o = (cnt_q <= ONE);

   a_r3_cnt_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !run_i) |=> $stable(cnt_q));

   a_r3_cnt_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && run_i && (cnt_q > ONE)) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
   parameter int ADDR_W = 23,
   parameter int LEN_W  = 3
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic              wrap_i,
   input  logic [LEN_W-1:0]  len_log2_i,
   output logic [ADDR_W-1:0] nxt_o
);
   logic [ADDR_W-1:0] inc;
   logic [ADDR_W-1:0] low_mask;

   always_comb begin
      inc      = cur_i + ADDR_W'(1);
      low_mask = ~({ADDR_W{1'b1}} << len_log2_i);
      if (wrap_i) begin
         nxt_o = (cur_i & ~low_mask) | (inc & low_mask);
      end else begin
         nxt_o = inc;
      end
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
   parameter int ADDR_W       = 23,
   parameter int BUS_W        = 16,
   parameter int LAT_W        = 4,
   parameter int MIN_LEN_LOG2 = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce_n,
   input  logic                    addr_vld_n,
   input  logic [BUS_W-1:0]        ad_bus,
   input  logic [ADDR_W-BUS_W-1:0] addr_hi,
   input  logic                    burst_en,
   input  logic [2:0]              burst_mode,
   input  logic [LAT_W-1:0]        init_lat,
   output logic [ADDR_W-1:0]       word_addr,
   output logic                    data_rdy
);
   import burst_seq_pkg::*;

   localparam int MAX_LEN_LOG2 = MIN_LEN_LOG2 + 2;
   localparam int LEN_W        = $clog2(MAX_LEN_LOG2 + 1);
   localparam int LEFT_W       = MAX_LEN_LOG2;

   generate
      if (ADDR_W <= BUS_W) begin : g_addr_w_chk
         $error("burst_addr_seq: ADDR_W must exceed BUS_W");
      end
      if (MAX_LEN_LOG2 >= ADDR_W) begin : g_len_chk
         $error("burst_addr_seq: longest burst must fit inside the address");
      end
      if (MIN_LEN_LOG2 < 1) begin : g_min_chk
         $error("burst_addr_seq: MIN_LEN_LOG2 must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] bus_addr;
   assign bus_addr = {addr_hi, ad_bus};

   seq_state_e        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wrap_q;
   logic              fixed_q;
   logic [LEN_W-1:0]  lg_q;
   logic [LEFT_W-1:0] left_q;

   logic              dec_wrap;
   logic              dec_fixed;
   logic [LEN_W-1:0]  dec_lg;
   logic [LEFT_W-1:0] left_init;
   logic [ADDR_W-1:0] step_nxt;
   logic              lat_done;
   logic              capture;

   assign capture   = burst_en && !ce_n && !addr_vld_n;
   assign left_init = ~({LEFT_W{1'b1}} << dec_lg);

   burst_mode_dec #(
      .MIN_LEN_LOG2 (MIN_LEN_LOG2),
      .LEN_W        (LEN_W)
   ) mode_dec_i (
      .mode_code  (burst_mode),
      .wrap_o     (dec_wrap),
      .fixed_o    (dec_fixed),
      .len_log2_o (dec_lg)
   );

   burst_lat_ctr #(
      .LAT_W (LAT_W)
   ) lat_ctr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (capture),
      .lat_i     (init_lat),
      .run_i     (st_q == SEQ_WAIT),
      .expired_o (lat_done)
   );

   burst_addr_step #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) addr_step_i (
      .cur_i      (addr_q),
      .wrap_i     (wrap_q),
      .len_log2_i (lg_q),
      .nxt_o      (step_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         addr_q  <= '0;
         wrap_q  <= 1'b0;
         fixed_q <= 1'b0;
         lg_q    <= '0;
         left_q  <= '0;
      end else if (!burst_en) begin
         st_q <= SEQ_IDLE;
         if (!ce_n && !addr_vld_n) begin
            addr_q <= bus_addr;
         end
      end else if (ce_n) begin
         st_q <= SEQ_IDLE;
      end else if (!addr_vld_n) begin
         st_q    <= SEQ_WAIT;
         addr_q  <= bus_addr;
         wrap_q  <= dec_wrap;
         fixed_q <= dec_fixed;
         lg_q    <= dec_lg;
         left_q  <= left_init;
      end else begin
         case (st_q)
            SEQ_WAIT: begin
               if (lat_done) begin
                  st_q <= SEQ_BURST;
               end
            end
            SEQ_BURST: begin
               if (fixed_q && (left_q == '0)) begin
                  st_q <= SEQ_DONE;
               end else begin
                  addr_q <= step_nxt;
                  left_q <= left_q - LEFT_W'(1);
               end
            end
            default: st_q <= st_q;
         endcase
      end
   end

   always_comb begin
      if (!burst_en && !ce_n && !addr_vld_n) begin
         word_addr = bus_addr;
      end else begin
         word_addr = addr_q;
      end
      data_rdy = burst_en ? (st_q == SEQ_BURST) : 1'b1;
   end

   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> ((addr_q == $past(bus_addr)) && (st_q == SEQ_WAIT)));

   a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_en && !ce_n && addr_vld_n && (st_q == SEQ_WAIT)) |=> $stable(addr_q));

   a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_en && !ce_n && addr_vld_n && (st_q == SEQ_BURST) && !wrap_q && !fixed_q)
      |=> ((addr_q - $past(addr_q)) == ADDR_W'(1)));

   a_r5_wrap_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_en && !ce_n && addr_vld_n && (st_q == SEQ_BURST) && wrap_q)
      |=> ($stable(addr_q[ADDR_W-1:MAX_LEN_LOG2]) && (addr_q != $past(addr_q))));

   a_r7_done_low: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_en && (st_q == SEQ_DONE)) |-> !data_rdy);

   a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_en && !ce_n && addr_vld_n && (st_q == SEQ_DONE))
      |=> ($stable(addr_q) && (st_q == SEQ_DONE)));

   a_r9_async_nocount: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_en && addr_vld_n) |=> $stable(addr_q));

   a_r10_ce_end: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_en && ce_n) |=> ((st_q == SEQ_IDLE) && $stable(addr_q)));

endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1;
   logic        addr_vld_n = 1'b1;
   logic [15:0] ad_bus = '0;
   logic [6:0]  addr_hi = '0;
   logic        burst_en = 1'b0;
   logic [2:0]  burst_mode = '0;
   logic [3:0]  init_lat = '0;
   logic [22:0] word_addr;
   logic        data_rdy;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   burst_addr_seq dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .addr_vld_n (addr_vld_n),
      .ad_bus     (ad_bus),
      .addr_hi    (addr_hi),
      .burst_en   (burst_en),
      .burst_mode (burst_mode),
      .init_lat   (init_lat),
      .word_addr  (word_addr),
      .data_rdy   (data_rdy)
   );

   // {mode[2:0], start[22:0], latency[3:0]}
   localparam logic [29:0] VECS [8] = '{
      {3'b000, 23'h123456, 4'd3},
      {3'b001, 23'h00000E, 4'd1},
      {3'b010, 23'h4000FB, 4'd2},
      {3'b011, 23'h7FFFFE, 4'd4},
      {3'b100, 23'h000005, 4'd1},
      {3'b101, 23'h12340C, 4'd2},
      {3'b110, 23'h00001E, 4'd0},
      {3'b111, 23'h7FFFFA, 4'd2}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string mode_req(input logic [2:0] m);
      case (m)
         3'b001, 3'b010, 3'b011: return "R5";
         3'b100, 3'b101, 3'b110: return "R6/R7";
         3'b111:                 return "R8";
         default:                return "R4";
      endcase
   endfunction

   function automatic int mode_lg(input logic [2:0] m);
      case (m)
         3'b001, 3'b100: return 3;
         3'b010, 3'b101: return 4;
         3'b011, 3'b110: return 5;
         default:        return 0;
      endcase
   endfunction

   function automatic logic [22:0] exp_addr(input logic [2:0] m, input logic [22:0] s, input int i);
      int          lg;
      logic [22:0] msk;
      lg  = mode_lg(m);
      msk = 23'((1 << lg) - 1);
      if (m >= 3'b100 && m <= 3'b110 && i >= (1 << lg)) return s + msk;
      if (m >= 3'b001 && m <= 3'b011) return (s & ~msk) | ((s + 23'(i)) & msk);
      return s + 23'(i);
   endfunction

   function automatic logic exp_rdy(input logic [2:0] m, input int i);
      if (m >= 3'b100 && m <= 3'b110 && i >= (1 << mode_lg(m))) return 1'b0;
      return 1'b1;
   endfunction

   task automatic capture(input logic [2:0] m, input logic [22:0] s, input logic [3:0] l);
      @(negedge clk);
      burst_en   = 1'b1;
      ce_n       = 1'b0;
      addr_vld_n = 1'b0;
      ad_bus     = s[15:0];
      addr_hi    = s[22:16];
      burst_mode = m;
      init_lat   = l;
      @(posedge clk);
      @(negedge clk);
      addr_vld_n = 1'b1;
      ad_bus     = 16'hDEAD;
      addr_hi    = 7'h2A;
   endtask

   task automatic wait_ready(input logic [3:0] l, input string req);
      int n = 0;
      while (!data_rdy && n < 40) begin
         @(posedge clk);
         @(negedge clk);
         n++;
      end
      check(n == ((l == 0) ? 1 : int'(l)), req, "ready latency", n, (l == 0) ? 1 : l);
   endtask

   task automatic run_vec(input logic [29:0] v);
      logic [2:0]  m = v[29:27];
      logic [22:0] s = v[26:4];
      logic [3:0]  l = v[3:0];
      capture(m, s, l);
      // R2: start address visible, not yet ready; garbage on bus ignored
      check(word_addr == s, "R2", "captured addr", word_addr, s);
      check(data_rdy == 1'b0, "R2", "rdy after capture", data_rdy, 0);
      wait_ready(l, "R3");
      for (int i = 0; i < 12; i++) begin
         if (i > 0) begin
            @(posedge clk);
            @(negedge clk);
         end
         check(word_addr == exp_addr(m, s, i), mode_req(m), "burst addr",
               word_addr, exp_addr(m, s, i));
         check(data_rdy == exp_rdy(m, i), mode_req(m), "burst rdy",
               data_rdy, exp_rdy(m, i));
      end
   endtask

   initial begin : watchdog
      #(10 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: reset state
      check(data_rdy == 1'b1, "R1", "async rdy in reset", data_rdy, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(word_addr == 23'h0, "R1", "addr after reset", word_addr, 0);
      check(data_rdy == 1'b1, "R1", "rdy async idle", data_rdy, 1);
      burst_en = 1'b1;
      ce_n     = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(data_rdy == 1'b0, "R1", "rdy sync idle", data_rdy, 0);

      // table walk: R2..R8
      for (int k = 0; k < 8; k++) begin
         run_vec(VECS[k]);
      end

      // R7: fresh capture after a finished linear burst
      run_vec({3'b100, 23'h000005, 4'd1});
      capture(3'b000, 23'h0ABCDE, 4'd1);
      check(word_addr == 23'h0ABCDE, "R7", "recapture after done", word_addr, 23'h0ABCDE);
      wait_ready(4'd1, "R7");
      @(posedge clk);
      @(negedge clk);
      check(word_addr == 23'h0ABCDF, "R7", "counting after recapture", word_addr, 23'h0ABCDF);

      // R9: asynchronous pass-through and hold
      @(negedge clk);
      burst_en   = 1'b0;
      ce_n       = 1'b0;
      addr_vld_n = 1'b0;
      addr_hi    = 7'h55;
      ad_bus     = 16'h3C3C;
      #1;
      check(word_addr == 23'h553C3C, "R9", "async flow", word_addr, 23'h553C3C);
      check(data_rdy == 1'b1, "R9", "async rdy", data_rdy, 1);
      ad_bus = 16'h1111;
      #1;
      check(word_addr == 23'h551111, "R9", "async follow", word_addr, 23'h551111);
      @(posedge clk);
      @(negedge clk);
      addr_vld_n = 1'b1;
      ad_bus     = 16'hFFFF;
      repeat (3) begin
         @(posedge clk);
         @(negedge clk);
      end
      check(word_addr == 23'h551111, "R9", "async hold no count", word_addr, 23'h551111);
      check(data_rdy == 1'b1, "R9", "async rdy held", data_rdy, 1);

      // R10: chip enable drop mid-burst
      capture(3'b000, 23'h000100, 4'd1);
      wait_ready(4'd1, "R10");
      repeat (2) begin
         @(posedge clk);
         @(negedge clk);
      end
      ce_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(data_rdy == 1'b0, "R10", "rdy after ce high", data_rdy, 0);
      check(word_addr == 23'h000102, "R10", "addr hold on ce high", word_addr, 23'h000102);
      ce_n = 1'b0;
      repeat (2) begin
         @(posedge clk);
         @(negedge clk);
      end
      check(data_rdy == 1'b0, "R10", "no resume without capture", data_rdy, 0);
      check(word_addr == 23'h000102, "R10", "addr still held", word_addr, 23'h000102);

      // R11: capture during an active burst restarts it
      capture(3'b000, 23'h000200, 4'd1);
      wait_ready(4'd1, "R11");
      repeat (3) begin
         @(posedge clk);
         @(negedge clk);
      end
      capture(3'b001, 23'h000777, 4'd2);
      check(word_addr == 23'h000777, "R11", "restart addr", word_addr, 23'h000777);
      check(data_rdy == 1'b0, "R11", "restart rdy low", data_rdy, 0);
      wait_ready(4'd2, "R11");
      @(posedge clk);
      @(negedge clk);
      check(word_addr == 23'h000770, "R11", "restart uses new wrap mode", word_addr, 23'h000770);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule